// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Decoder

This block sits after clock and data recovery on a bipolar line receiver. Each cycle of the recovered clock it takes one line symbol as two rail bits: a positive mark, a negative mark, both rails low (a space), or both rails high (an invalid symbol). It removes the zero-substitution codes the transmitter inserted and produces NRZ data. A mode input selects the code. With the input low the block decodes the three-zero code used at DS3 and STS-1 rates. With it high it decodes the four-zero code used at E3. The block also raises a one-cycle line-code-violation pulse. The pulse covers any bipolar violation that is not a legal substitution, any invalid symbol, and any run of spaces as long as the code's substitution length.

A legal substitution ends in a violation mark V. A violation mark is a mark with the same polarity as the mark before it. In the three-zero code a legal V follows one space (patterns 00V and B0V). In the four-zero code a legal V follows two spaces (patterns 000V and B00V). Across the whole line, the number of marks between two successive violation marks must be odd. The first violation after reset is exempt from this count. When a legal V is found, the V and the symbol at the start of the substitution (the possible B pulse) are forced to zero on the way to the output. For this reason the output is delayed by one substitution length. A bypass input turns decoding off and passes both rails through with the same delay.

A small state machine tracks the polarity of the last mark. Its states are POL_NONE (no mark since reset), POL_POS and POL_NEG. From POL_NONE a positive mark moves it to POL_POS and a negative mark moves it to POL_NEG. From POL_POS a negative mark moves it to POL_NEG (alternation). From POL_NEG a positive mark moves it to POL_POS (alternation). A mark of the same polarity as the current state leaves the state unchanged and is classed as a violation mark. Spaces and invalid symbols never change the state.

Top module: `bzs_line_decoder`

## Requirements
- R1: With `code_sel_i` = 0, a line stream made with the three-zero code (00V when an odd number of marks has been sent since the last V, B0V when even) is decoded back to the original NRZ bits. Output `nrz_o` shows each symbol 3 cycles after it is sampled, and `lcv_o` stays low.
- R2: With `code_sel_i` = 1, a line stream made with the four-zero code (000V when odd, B00V when even) is decoded back to the original NRZ bits. Output `nrz_o` shows each symbol 4 cycles after it is sampled, and `lcv_o` stays low.
- R3: A violation mark is illegal when the symbol before it is not a space (three-zero code), or when either of the two symbols before it is not a space (four-zero code). An illegal violation mark gives `nrz_o` = 1 and `lcv_o` = 1 in that symbol's output cycle.
- R4: A violation mark with the right shape is illegal when an even number of marks has passed since the previous violation mark. It then gives `nrz_o` = 1 and `lcv_o` = 1. A violation mark with the right shape after an odd count is legal: it and the symbol at the start of its substitution come out as 0.
- R5: In the three-zero code, the third consecutive space raises `lcv_o` for that symbol only. Later spaces in the same run raise no further pulse.
- R6: In the four-zero code, three consecutive spaces raise no pulse. The fourth consecutive space raises `lcv_o` for that symbol.
- R7: A symbol with both rails high gives `lcv_o` = 1 and `nrz_o` = 0 in its output cycle.
- R8: With `bypass_i` = 1, `nrz_o` carries the positive rail and `rail_n_o` carries the negative rail, delayed by the mode's latency (3 or 4 cycles), and `lcv_o` stays 0. With `bypass_i` = 0, `rail_n_o` is 0.
- R9: Synchronous active-high `rst` clears the polarity state, the space counter and the delay line. All outputs are 0 after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_p_i | input | 1 | Positive-mark rail |
| rail_n_i | input | 1 | Negative-mark rail |
| code_sel_i | input | 1 | 0: three-zero code, 1: four-zero code |
| bypass_i | input | 1 | 1: pass rails through undecoded |
| nrz_o | output | 1 | Decoded NRZ data (positive rail in bypass) |
| rail_n_o | output | 1 | Negative rail in bypass, else 0 |
| lcv_o | output | 1 | One-cycle line code violation pulse |

## Verification
The clocked properties assume that `code_sel_i` and `bypass_i` stay constant for at least a full delay-line length. A change of either one would leave symbols of two settings in the pipe at the same time. The bench meets this by pulsing reset before every session and holding both controls fixed within it. Random sessions feed properly encoded streams built by a bench encoder from seeded random NRZ bits. Directed sessions place the malformed violation marks, wrong parity, long space runs and invalid symbols at known positions.

// File: rtl/bzs_pkg.sv
package bzs_pkg;

    // Polarity of the most recent single-rail mark.
    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_state_e;

    // One symbol as it moves through the delay line.
    typedef struct packed {
        logic data;   // NRZ bit, or positive rail in bypass
        logic aux;    // negative rail in bypass
        logic zero;   // symbol was a space
        logic lcv;    // violation flag for this symbol
    } bzs_stage_t;

endpackage

// File: rtl/bzs_pol_fsm.sv
module bzs_pol_fsm
    import bzs_pkg::*;
#(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4,
    parameter int HIST     = HDB3_RUN - 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mark_p,
    input  logic            mark_n,
    input  logic            hdb3,
    input  logic [HIST-1:0] zhist,    // zhist[k]: symbol k+1 cycles back was a space
    output logic            is_v,
    output logic            v_legal
);

    pol_state_e state_q, state_d;
    logic       par_odd_q;    // odd number of marks since last violation mark
    logic       seen_v_q;     // a violation mark has occurred since reset
    logic       shape_ok;
    int         need;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= POL_NONE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POL_NONE: begin
                if (mark_p)      state_d = POL_POS;
                else if (mark_n) state_d = POL_NEG;
            end
            POL_POS:  if (mark_n) state_d = POL_NEG;
            POL_NEG:  if (mark_p) state_d = POL_POS;
            default:  state_d = POL_NONE;
        endcase
    end

    // Outputs: classify the current mark
    always_comb begin
        is_v = 1'b0;
        unique case (state_q)
            POL_NONE: is_v = 1'b0;
            POL_POS:  is_v = mark_p;
            POL_NEG:  is_v = mark_n;
            default:  is_v = 1'b0;
        endcase
        need     = hdb3 ? (HDB3_RUN - 2) : (B3ZS_RUN - 2);
        shape_ok = 1'b1;
        for (int k = 0; k < HIST; k++) begin
            if (k < need && !zhist[k]) shape_ok = 1'b0;
        end
        v_legal = is_v && shape_ok && (!seen_v_q || par_odd_q);
    end

    // Mark parity between violation marks
    always_ff @(posedge clk) begin
        if (rst) begin
            par_odd_q <= 1'b0;
            seen_v_q  <= 1'b0;
        end else if (mark_p || mark_n) begin
            if (is_v) begin
                par_odd_q <= 1'b0;
                seen_v_q  <= 1'b1;
            end else begin
                par_odd_q <= ~par_odd_q;
            end
        end
    end

endmodule

// File: rtl/bzs_zero_run.sv
module bzs_zero_run #(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4,
    parameter int CNT_W    = $clog2(HDB3_RUN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic hdb3,
    input  logic idle,   // current symbol is a space
    output logic hit     // this space completes an excessive run
);

    localparam logic [CNT_W-1:0] THR_B3 = CNT_W'(B3ZS_RUN);
    localparam logic [CNT_W-1:0] THR_HD = CNT_W'(HDB3_RUN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr = hdb3 ? THR_HD : THR_B3;
        hit = idle && (cnt_q == thr - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !idle)       cnt_q <= '0;
        else if (cnt_q < thr)   cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/bzs_delay_line.sv
module bzs_delay_line
    import bzs_pkg::*;
#(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4,
    parameter int DEPTH    = HDB3_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdb3,
    input  logic             clr,       // clear the substitution's first symbol
    input  bzs_stage_t       stage_in,
    output bzs_stage_t       stage_out,
    output logic [DEPTH-1:0] zero_vec
);

    localparam int B3_TAP = B3ZS_RUN - 1;
    localparam int HD_TAP = HDB3_RUN - 1;
    localparam int B3_CLR = B3ZS_RUN - 2;
    localparam int HD_CLR = HDB3_RUN - 2;

    bzs_stage_t st [DEPTH];
    int         clr_at;

    assign clr_at = hdb3 ? HD_CLR : B3_CLR;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) st[i] <= '0;
        end else begin
            st[0] <= stage_in;
            for (int i = 1; i < DEPTH; i++) begin
                st[i] <= st[i-1];
                if (clr && clr_at == i - 1) st[i].data <= 1'b0;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_zero
            assign zero_vec[g] = st[g].zero;
        end
    endgenerate

    assign stage_out = hdb3 ? st[HD_TAP] : st[B3_TAP];

endmodule

// File: rtl/bzs_line_decoder.sv
module bzs_line_decoder
    import bzs_pkg::*;
#(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_p_i,
    input  logic rail_n_i,
    input  logic code_sel_i,
    input  logic bypass_i,
    output logic nrz_o,
    output logic rail_n_o,
    output logic lcv_o
);

    localparam int DEPTH = HDB3_RUN;
    localparam int HIST  = HDB3_RUN - 2;
    localparam int CNT_W = $clog2(HDB3_RUN + 1);

    logic             mark_p, mark_n, both, idle;
    logic             is_v, v_legal, run_hit, clr;
    logic [DEPTH-1:0] zero_vec;
    bzs_stage_t       stage_in, stage_out;

    always_comb begin
        mark_p = rail_p_i & ~rail_n_i;
        mark_n = rail_n_i & ~rail_p_i;
        both   = rail_p_i & rail_n_i;
        idle   = ~rail_p_i & ~rail_n_i;
    end

    bzs_pol_fsm #(
        .B3ZS_RUN (B3ZS_RUN),
        .HDB3_RUN (HDB3_RUN),
        .HIST     (HIST)
    ) pol_i (
        .clk     (clk),
        .rst     (rst),
        .mark_p  (mark_p),
        .mark_n  (mark_n),
        .hdb3    (code_sel_i),
        .zhist   (zero_vec[HIST-1:0]),
        .is_v    (is_v),
        .v_legal (v_legal)
    );

    bzs_zero_run #(
        .B3ZS_RUN (B3ZS_RUN),
        .HDB3_RUN (HDB3_RUN),
        .CNT_W    (CNT_W)
    ) run_i (
        .clk  (clk),
        .rst  (rst),
        .hdb3 (code_sel_i),
        .idle (idle),
        .hit  (run_hit)
    );

    always_comb begin
        stage_in.zero = idle;
        if (bypass_i) begin
            stage_in.data = rail_p_i;
            stage_in.aux  = rail_n_i;
            stage_in.lcv  = 1'b0;
            clr           = 1'b0;
        end else begin
            stage_in.data = (mark_p | mark_n) & ~v_legal;
            stage_in.aux  = 1'b0;
            stage_in.lcv  = (is_v & ~v_legal) | both | run_hit;
            clr           = v_legal;
        end
    end

    bzs_delay_line #(
        .B3ZS_RUN (B3ZS_RUN),
        .HDB3_RUN (HDB3_RUN),
        .DEPTH    (DEPTH)
    ) dly_i (
        .clk       (clk),
        .rst       (rst),
        .hdb3      (code_sel_i),
        .clr       (clr),
        .stage_in  (stage_in),
        .stage_out (stage_out),
        .zero_vec  (zero_vec)
    );

    assign nrz_o    = stage_out.data;
    assign rail_n_o = stage_out.aux;
    assign lcv_o    = stage_out.lcv;

endmodule

// File: rtl/bzs_line_decoder_chk.sv
module bzs_line_decoder_chk (
    input logic clk,
    input logic rst,
    input logic rail_p_i,
    input logic rail_n_i,
    input logic code_sel_i,
    input logic bypass_i,
    input logic nrz_o,
    input logic rail_n_o,
    input logic lcv_o
);

    // R9: outputs cleared after a reset edge
    p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (!nrz_o && !rail_n_o && !lcv_o));

    // R8: no violation pulse once bypass has been held through the pipe
    p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (bypass_i && $past(bypass_i) && $past(bypass_i, 2) && $past(bypass_i, 3)
         && $past(bypass_i, 4)) |-> !lcv_o);

    // R8: negative rail output idle while decoding
    p_neg_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!bypass_i && !$past(bypass_i) && !$past(bypass_i, 2) && !$past(bypass_i, 3)
         && !$past(bypass_i, 4)) |-> !rail_n_o);

    // R7: invalid symbol flagged three cycles later in the three-zero code
    p_both_b3_r7: assert property (@(posedge clk) disable iff (rst)
        (rail_p_i && rail_n_i && !bypass_i && !code_sel_i) |-> ##3 lcv_o);

    // R7: invalid symbol flagged four cycles later in the four-zero code
    p_both_hd_r7: assert property (@(posedge clk) disable iff (rst)
        (rail_p_i && rail_n_i && !bypass_i && code_sel_i) |-> ##4 lcv_o);

endmodule

bind bzs_line_decoder bzs_line_decoder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .rail_p_i   (rail_p_i),
    .rail_n_i   (rail_n_i),
    .code_sel_i (code_sel_i),
    .bypass_i   (bypass_i),
    .nrz_o      (nrz_o),
    .rail_n_o   (rail_n_o),
    .lcv_o      (lcv_o)
);

// File: tb/bzs_line_decoder_tb_top.sv
module bzs_line_decoder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_p_i = 1'b0, rail_n_i = 1'b0, code_sel_i = 1'b0, bypass_i = 1'b0;
    logic nrz_o, rail_n_o, lcv_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic sp [512];
    logic sn [512];
    logic ed [512];
    logic en [512];
    logic el [512];

    always #4 clk = ~clk;   // 125 MHz

    bzs_line_decoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .rail_p_i   (rail_p_i),
        .rail_n_i   (rail_n_i),
        .code_sel_i (code_sel_i),
        .bypass_i   (bypass_i),
        .nrz_o      (nrz_o),
        .rail_n_o   (rail_n_o),
        .lcv_o      (lcv_o)
    );

    function automatic int lat(bit mode);
        return mode ? 4 : 3;
    endfunction

    // Put one symbol into the arrays: 1 = positive, -1 = negative, 0 = space, 2 = both rails
    task automatic put(int i, int s, logic d, logic l);
        sp[i] = (s == 1) || (s == 2);
        sn[i] = (s == -1) || (s == 2);
        ed[i] = d; en[i] = 1'b0; el[i] = l;
    endtask

    // Random NRZ bits, encoded with the selected substitution code
    task automatic fill_encoded(int n, bit mode);
        int  run = 0, cnt = 0, len = mode ? 4 : 3;
        bit  lastpos = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic b = (($urandom % 100) < 40);
            ed[i] = b; en[i] = 1'b0; el[i] = 1'b0;
            if (b) begin
                lastpos = ~lastpos;
                sp[i] = lastpos; sn[i] = ~lastpos;
                cnt++; run = 0;
            end else begin
                sp[i] = 1'b0; sn[i] = 1'b0;
                run++;
                if (run == len) begin
                    if (cnt % 2 == 0) begin
                        lastpos = ~lastpos;
                        sp[i-len+1] = lastpos; sn[i-len+1] = ~lastpos;
                    end
                    sp[i] = lastpos; sn[i] = ~lastpos;
                    cnt = 0; run = 0;
                end
            end
        end
    endtask

    task automatic fill_bypass(int n);
        for (int i = 0; i < n; i++) begin
            sp[i] = $urandom % 2; sn[i] = $urandom % 2;
            ed[i] = sp[i]; en[i] = sn[i]; el[i] = 1'b0;
        end
    endtask

    task automatic run_session(int n, bit mode, bit byp, string req);
        int l = lat(mode);
        @(negedge clk);
        rst = 1'b1; code_sel_i = mode; bypass_i = byp;
        rail_p_i = 1'b0; rail_n_i = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (nrz_o !== 1'b0 || rail_n_o !== 1'b0 || lcv_o !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: nrz/neg/lcv=%b%b%b expected 000", nrz_o, rail_n_o, lcv_o);
        end
        rst = 1'b0;
        rail_p_i = sp[0]; rail_n_i = sn[0];
        for (int j = 1; j < n + l; j++) begin
            @(negedge clk);
            if (j >= l) begin
                int i = j - l;
                checks++;
                if (nrz_o !== ed[i] || rail_n_o !== en[i] || lcv_o !== el[i]) begin
                    errors++;
                    $display("FAIL %s sym %0d: nrz/neg/lcv=%b%b%b expected %b%b%b",
                             req, i, nrz_o, rail_n_o, lcv_o, ed[i], en[i], el[i]);
                end
            end
            rail_p_i = (j < n) ? sp[j] : 1'b0;
            rail_n_i = (j < n) ? sn[j] : 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd7781));

        // R1 / R2: encoded random streams decode cleanly
        fill_encoded(300, 1'b0); run_session(300, 1'b0, 1'b0, "R1");
        fill_encoded(300, 1'b1); run_session(300, 1'b1, 1'b0, "R2");

        // R3: violation right after a mark (three-zero code)
        put(0, 1, 1, 0); put(1, -1, 1, 0); put(2, 1, 1, 0); put(3, 1, 1, 1);
        run_session(4, 1'b0, 1'b0, "R3");
        // R3: four-zero code needs two spaces before the violation
        put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 1, 1, 1);
        run_session(3, 1'b1, 1'b0, "R3");

        // R4: legal 00V, then even parity 00V flagged, then legal B0V cleared
        put(0, 1, 1, 0);  put(1, 0, 0, 0);  put(2, 0, 0, 0);  put(3, 1, 0, 0);
        put(4, -1, 1, 0); put(5, 1, 1, 0);  put(6, 0, 0, 0);  put(7, 0, 0, 0);
        put(8, 1, 1, 1);  put(9, -1, 0, 0); put(10, 0, 0, 0); put(11, -1, 0, 0);
        run_session(12, 1'b0, 1'b0, "R4");

        // R5: one pulse on the third space of a long run
        put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 0, 0, 1);
        put(4, 0, 0, 0); put(5, 0, 0, 0); put(6, -1, 1, 0);
        run_session(7, 1'b0, 1'b0, "R5");

        // R6: three spaces pass, the fourth is flagged
        put(0, 1, 1, 0); put(1, 0, 0, 0); put(2, 0, 0, 0); put(3, 0, 0, 0);
        put(4, -1, 1, 0); put(5, 0, 0, 0); put(6, 0, 0, 0); put(7, 0, 0, 0);
        put(8, 0, 0, 1); put(9, 1, 1, 0);
        run_session(10, 1'b1, 1'b0, "R6");

        // R7: both rails high, in each code
        put(0, 1, 1, 0); put(1, 2, 0, 1); put(2, -1, 1, 0);
        run_session(3, 1'b0, 1'b0, "R7");
        put(0, 1, 1, 0); put(1, 2, 0, 1); put(2, -1, 1, 0);
        run_session(3, 1'b1, 1'b0, "R7");

        // R8: bypass with raw random rails, both latencies
        fill_bypass(120); run_session(120, 1'b0, 1'b1, "R8");
        fill_bypass(120); run_session(120, 1'b1, 1'b1, "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule